// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block stores incoming network frames in the receive part of a shared packet memory. The bottom of that memory is kept for transmit data. The receive ring begins at the end of the transmit area and runs to the top of memory, then wraps back to the ring base. Two select inputs set the total memory size and the transmit area size. Both are sampled while reset is asserted and must stay constant while the block runs.

Frames arrive one byte per cycle. A start flag marks the first data byte and an end flag marks the last one; the end byte also carries a status byte. Each frame slot begins on an eight-byte boundary. It opens with a four-byte header, which holds the status, a zero byte and the data length (low byte first). The data bytes are written into memory as they arrive. The header is written only after the last byte, and only if the frame fits.

A host read pointer marks the oldest byte the host still needs. The block compares free space against each byte and against the whole padded slot. If the frame does not fit, it drops the frame, leaves the write pointer where it was and pulses an overflow flag. A completion pulse and a running frame count are provided for interrupt logic.

Top module: `rx_ring_writer`

## Requirements
- R1: During reset and in the first cycle after it: `wr_ptr` equals the ring base `2048 << tx_sel`; `mem_we`, `frame_done` and `overflow` are 0; `frame_count` is 0.
- R2: The k-th data byte of a frame (counting from 0) whose slot starts at address S is written to S+4+k. An address that reaches the ring top `8192 << mem_sel` continues at the ring base. The write appears on the memory port in the cycle after the byte is accepted.
- R3: After the last byte of a frame that fits, the block writes four header bytes in the next four cycles, at S, S+1, S+2 and S+3. Their values are the status byte, 0x00, length bits 7:0 and length bits 15:8. The length counts data bytes only.
- R4: After a frame is stored, `wr_ptr` advances by 4 plus the length, rounded up to a multiple of 8, modulo the ring. `wr_ptr` is always a multiple of 8.
- R5: `frame_done` pulses for one cycle, in the same cycle as the fourth header write, and `frame_count` increments by one at that point.
- R6: Free space is `rd_ptr - wr_ptr` when `rd_ptr > wr_ptr`, and otherwise the ring size minus `wr_ptr - rd_ptr`. A data byte at slot offset 4+k is written only if 4+k is below free space and no earlier byte of the frame was refused.
- R7: A frame is dropped if any of its bytes was refused, or if its padded slot size is not strictly below free space. When a frame is dropped, `overflow` pulses in the cycle after the last byte. There are no header writes, and `wr_ptr` and `frame_count` do not change.
- R8: Ignored inputs: a valid byte without the start flag while the block is idle, and any input during the four header cycles. Both cause no memory write and no state change.
- R9: The memory select changes the ring top. With 16 KB total and an 8 KB transmit area, data wraps from address 16383 to 8192.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_sel | input | 2 | Total memory: 8, 16, 32 or 64 KB for 0..3 |
| tx_sel | input | 2 | Transmit area: 2, 4, 8 or 16 KB for 0..3 |
| in_valid | input | 1 | A frame byte is present |
| in_sof | input | 1 | The byte is the first of a frame |
| in_eof | input | 1 | The byte is the last of a frame |
| in_data | input | 8 | Frame byte |
| in_status | input | 8 | Frame status, taken with the last byte |
| rd_ptr | input | 16 | Host read address inside the ring |
| mem_we | output | 1 | Byte write strobe |
| mem_addr | output | 16 | Byte write address |
| mem_wdata | output | 8 | Byte write data |
| frame_done | output | 1 | One-cycle pulse when a frame is stored |
| overflow | output | 1 | One-cycle pulse when a frame is dropped |
| frame_count | output | CNT_W | Number of stored frames |
| wr_ptr | output | 16 | Start of the next frame slot |

## Verification
Single-byte and odd-length frames show whether the length field and the rounding to eight bytes agree. A run of large frames with the read pointer kept at the write pointer makes one frame cross the ring top. This separates correct wrapping from writes past the top or header bytes that are split across the wrap. Read pointers placed 64 and then 8 bytes ahead test both drop rules:
- a frame whose padded slot exactly equals free space is dropped;
- a frame one slot smaller is stored;
- a frame that runs out of room part-way through is dropped.

Stray bytes during header writeback and in idle, and a second memory configuration, check that ignored input stays ignored and that the ring bounds follow the selects.

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mem_sel,
  input  logic [1:0]       tx_sel,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic [7:0]       in_data,
  input  logic [7:0]       in_status,
  input  logic [15:0]      rd_ptr,
  output logic             mem_we,
  output logic [15:0]      mem_addr,
  output logic [7:0]       mem_wdata,
  output logic             frame_done,
  output logic             overflow,
  output logic [CNT_W-1:0] frame_count,
  output logic [15:0]      wr_ptr
);

  typedef enum logic [1:0] {IDLE, RECV, HDR} state_t;

  function automatic logic [16:0] slot_size(input logic [16:0] n);
    return (n + 17'd11) & ~17'd7;
  endfunction

  state_t      st;
  logic [1:0]  hidx;
  logic [15:0] cp;
  logic [15:0] len;
  logic        drop;
  logic [7:0]  stat;

  wire [16:0] base = 17'd2048 << tx_sel;
  wire [16:0] top  = 17'd8192 << mem_sel;
  wire [16:0] span = top - base;
  wire [16:0] wp   = {1'b0, wr_ptr};
  wire [16:0] rd   = {1'b0, rd_ptr};
  wire [16:0] free = (rd > wp) ? rd - wp : span - (wp - rd);

  wire        start = (st == IDLE) && in_valid && in_sof;
  wire        take  = start || ((st == RECV) && in_valid);
  wire [16:0] pos   = start ? wp + 17'd4 : {1'b0, cp};
  wire [16:0] used  = start ? 17'd4 : 17'd4 + {1'b0, len};
  wire        fits  = !(st == RECV && drop) && (used < free);
  wire [15:0] nlen  = start ? 16'd1 : len + 16'd1;
  wire        fit_all = fits && (slot_size({1'b0, nlen}) < free);
  wire [16:0] pos_nx = (pos + 17'd1 == top) ? base : pos + 17'd1;
  wire [16:0] wsum  = wp + slot_size({1'b0, len});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= IDLE;
      hidx        <= 2'd0;
      cp          <= 16'(base);
      len         <= 16'd0;
      drop        <= 1'b0;
      stat        <= 8'd0;
      wr_ptr      <= 16'(base);
      mem_we      <= 1'b0;
      mem_addr    <= 16'd0;
      mem_wdata   <= 8'd0;
      frame_done  <= 1'b0;
      overflow    <= 1'b0;
      frame_count <= '0;
    end else begin
      mem_we     <= 1'b0;
      frame_done <= 1'b0;
      overflow   <= 1'b0;
      if (st == HDR) begin
        mem_we   <= 1'b1;
        mem_addr <= wr_ptr + {14'd0, hidx};
        case (hidx)
          2'd0:    mem_wdata <= stat;
          2'd1:    mem_wdata <= 8'd0;
          2'd2:    mem_wdata <= len[7:0];
          default: mem_wdata <= len[15:8];
        endcase
        hidx <= hidx + 2'd1;
        if (hidx == 2'd3) begin
          st          <= IDLE;
          wr_ptr      <= 16'((wsum >= top) ? wsum - span : wsum);
          frame_done  <= 1'b1;
          frame_count <= frame_count + CNT_W'(1);
        end
      end else if (take) begin
        len  <= nlen;
        cp   <= 16'(pos_nx);
        drop <= !fits;
        if (fits) begin
          mem_we    <= 1'b1;
          mem_addr  <= 16'(pos);
          mem_wdata <= in_data;
        end
        if (in_eof) begin
          if (fit_all) begin
            st   <= HDR;
            hidx <= 2'd0;
            stat <= in_status;
          end else begin
            st       <= IDLE;
            overflow <= 1'b1;
          end
        end else begin
          st <= RECV;
        end
      end
    end
  end

  a_r2_write_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ({1'b0, mem_addr} >= base && {1'b0, mem_addr} < top));
  a_r4_ptr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ptr[2:0] == 3'd0);
  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> frame_count == $past(frame_count) + CNT_W'(1));
  a_r7_drop_holds_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> ($stable(wr_ptr) && $stable(frame_count)));
  a_r7_done_or_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !(overflow && frame_done));

endmodule

// File: tb/rx_ring_writer_test.sv
module rx_ring_writer_test;
  logic clk = 0, rst_n = 0;
  logic [1:0] mem_sel = 0, tx_sel = 0;
  logic in_valid = 0, in_sof = 0, in_eof = 0;
  logic [7:0] in_data = 0, in_status = 0;
  logic [15:0] rd_ptr = 16'd2048;
  logic mem_we, frame_done, overflow;
  logic [15:0] mem_addr, wr_ptr;
  logic [7:0] mem_wdata;
  logic [15:0] frame_count;

  rx_ring_writer #(.CNT_W(16)) uut (.*);

  always #5 clk = ~clk;

  int total = 0, fails = 0;
  task automatic check(string tag, bit ok, int got, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got %0d exp %0d", tag, got, exp);
    end
  endtask

  // reference model
  int m_base, m_top, m_span, m_wp, m_start, m_k, m_st, m_hidx, m_stat, m_cnt;
  bit m_bad, armed = 0;
  bit e_we, e_done, e_ovf, e_hdr;
  int e_addr, e_data;

  function automatic int fspace(int rd, int wp);
    return (rd > wp) ? rd - wp : m_span - (wp - rd);
  endfunction

  always @(posedge clk) begin
    armed <= 1;
    m_base = 2048 << tx_sel;
    m_top  = 8192 << mem_sel;
    m_span = m_top - m_base;
    e_we = 0; e_done = 0; e_ovf = 0; e_hdr = 0;
    if (!rst_n) begin
      m_wp = m_base; m_st = 0; m_cnt = 0; e_addr = 0; e_data = 0;
    end else if (m_st == 2) begin
      e_we = 1; e_hdr = 1;
      e_addr = m_wp + m_hidx;
      e_data = (m_hidx == 0) ? m_stat : (m_hidx == 1) ? 0 :
               (m_hidx == 2) ? (m_k % 256) : (m_k / 256) % 256;
      m_hidx++;
      if (m_hidx == 4) begin
        m_wp += ((4 + m_k + 7) / 8) * 8;
        if (m_wp >= m_top) m_wp -= m_span;
        m_st = 0; e_done = 1; m_cnt++;
      end
    end else if (in_valid && (m_st == 1 || in_sof)) begin
      int off, a, fr;
      if (m_st == 0) begin m_start = m_wp; m_k = 0; m_bad = 0; end
      fr = fspace(int'(rd_ptr), m_wp);
      off = 4 + m_k;
      a = m_start + off;
      if (a >= m_top) a -= m_span;
      if (!m_bad && off < fr) begin e_we = 1; e_addr = a; e_data = int'(in_data); end
      else m_bad = 1;
      m_k++;
      if (in_eof) begin
        if (!m_bad && ((4 + m_k + 7) / 8) * 8 < fr) begin
          m_st = 2; m_hidx = 0; m_stat = int'(in_status);
        end else begin
          m_st = 0; e_ovf = 1;
        end
      end else m_st = 1;
    end
  end

  int wcount = 0, ovf_seen = 0, last_addr = -1;
  bit wrapped = 0;
  always @(negedge clk) begin
    if (armed && rst_n) begin
      string t;
      t = e_hdr ? "R3" : "R2";
      check({t, " mem_we"}, mem_we == e_we, int'(mem_we), int'(e_we));
      if (e_we && mem_we) begin
        check({t, " mem_addr"}, int'(mem_addr) == e_addr, int'(mem_addr), e_addr);
        check({t, " mem_wdata"}, int'(mem_wdata) == e_data, int'(mem_wdata), e_data);
      end
      check("R4 wr_ptr", int'(wr_ptr) == m_wp, int'(wr_ptr), m_wp);
      check("R5 frame_done", frame_done == e_done, int'(frame_done), int'(e_done));
      check("R5 frame_count", int'(frame_count) == m_cnt, int'(frame_count), m_cnt);
      check("R7 overflow", overflow == e_ovf, int'(overflow), int'(e_ovf));
      if (mem_we) begin
        wcount++;
        if (last_addr == m_top - 1 && int'(mem_addr) == m_base) wrapped = 1;
        last_addr = int'(mem_addr);
      end
      if (overflow) ovf_seen++;
    end
  end

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 0; in_sof = 0; in_eof = 0;
    end
  endtask

  task automatic frame(int len, int st, int seed, int junk);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1; in_sof = (i == 0); in_eof = (i == len - 1);
      in_data = 8'(seed + i); in_status = 8'(st);
    end
    for (int j = 0; j < junk; j++) begin
      @(negedge clk);
      in_valid = 1; in_sof = (j == 1); in_eof = (j == 2); in_data = 8'hEE;
    end
    idle(6);
  endtask

  task automatic do_reset(int ms, int ts);
    @(negedge clk);
    rst_n = 0; mem_sel = 2'(ms); tx_sel = 2'(ts);
    idle(3);
    rst_n = 1;
  endtask

  initial begin
    #1_500_000;
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int p, cnt0;
    idle(3);
    // R1 during reset
    check("R1 wr_ptr", wr_ptr == 16'd2048, int'(wr_ptr), 2048);
    check("R1 mem_we", mem_we == 0, int'(mem_we), 0);
    check("R1 frame_count", frame_count == 0, int'(frame_count), 0);
    check("R1 frame_done", frame_done == 0, int'(frame_done), 0);
    check("R1 overflow", overflow == 0, int'(overflow), 0);
    rst_n = 1;
    // R8: stray bytes while idle
    wcount = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); in_valid = 1; in_sof = 0; in_data = 8'h55;
    end
    idle(3);
    check("R8 idle writes", wcount == 0, wcount, 0);
    frame(1, 8'h21, 10, 0);
    check("R4 single byte slot", wr_ptr == 16'd2056, int'(wr_ptr), 2056);
    frame(12, 8'h22, 40, 0);
    frame(3, 8'h23, 90, 0);
    // R8: junk during header writeback
    wcount = 0;
    cnt0 = int'(frame_count);
    frame(5, 8'h24, 7, 4);
    check("R8 junk writes", wcount == 9, wcount, 9);
    check("R8 junk frames", int'(frame_count) == cnt0 + 1, int'(frame_count), cnt0 + 1);
    // R2 wrap with read pointer kept at write pointer
    wrapped = 0;
    for (int f = 0; f < 8; f++) begin
      rd_ptr = wr_ptr;
      frame(1000, f, f * 3, 0);
    end
    check("R2 wrap seen", wrapped == 1, int'(wrapped), 1);
    // R6/R7 overflow cases
    ovf_seen = 0;
    p = int'(wr_ptr) + 64;
    if (p >= 8192) p -= 6144;
    rd_ptr = 16'(p);
    cnt0 = int'(frame_count);
    frame(56, 8'h31, 1, 0);
    check("R7 exact fit dropped", ovf_seen == 1, ovf_seen, 1);
    frame(52, 8'h32, 2, 0);
    check("R7 smaller slot stored", int'(frame_count) == cnt0 + 1, int'(frame_count), cnt0 + 1);
    frame(10, 8'h33, 3, 0);
    check("R6 partial frame dropped", ovf_seen == 2, ovf_seen, 2);
    // R9: other configuration
    do_reset(1, 2);
    check("R9 new base", wr_ptr == 16'd8192, int'(wr_ptr), 8192);
    wrapped = 0;
    for (int f = 0; f < 6; f++) begin
      rd_ptr = wr_ptr;
      frame(2000, 8'h40 + f, f, 0);
    end
    check("R9 wrap at 16K top", wrapped == 1, int'(wrapped), 1);
    do_reset(3, 3);
    rd_ptr = 16'd16384;
    frame(7, 8'h51, 5, 0);
    check("R9 64K base slot", wr_ptr == 16'd16400, int'(wr_ptr), 16400);
    idle(4);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule